// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor with Alarm Substitution

This block watches one receive line for loss of signal. It runs on the recovered pulse-interval clock and takes one flag per interval that says whether a pulse was seen. The flag is already qualified against the amplitude threshold upstream. After a run of intervals with no pulse, the block declares loss. While loss is active, it waits for a received pulse. That pulse opens a fixed-length observation window, and loss is cleared only if the pulse density over that window reaches one in eight. A window that fails is dropped, and the next received pulse opens a fresh one.

Loss is reported on a status output and by a one-cycle interrupt pulse, which can be masked. The status stays live whatever loopback the surrounding datapath uses. While a line monitor mode is selected, loss reporting is held off.

While loss is active, two separate enables can replace line traffic with an all-ones alarm pattern:
- On the receive side, the data goes to constant ones and the receive clock output switches to the master clock.
- On the transmit side, the dual-rail line outputs send alternating marks and the transmit clock output switches to the master clock.

The declare length and the clear window length are chosen by a standard select (T1 or E1) together with a criteria select.

Top module: `los_alarm_unit`

## Requirements
- R1: While and just after `rst` is high, `los`, `los_irq`, `rx_data_out`, `tx_pos_out` and `tx_neg_out` are 0.
- R2: With loss inactive, `los` rises on the clock edge that samples the N-th consecutive interval with `pulse_in` = 0. Any sampled pulse restarts this count from zero.
- R3: The lengths are selected as follows:
  - `crit_sel` = 0, `e1_mode` = 1: N = M = 32.
  - `crit_sel` = 0, `e1_mode` = 0: N = M = 175.
  - `crit_sel` = 1, `e1_mode` = 1: N = M = 2048.
  - `crit_sel` = 1, `e1_mode` = 0: N = M = 1544.
- R4: While loss is active, the clear window opens only on an interval with `pulse_in` = 1. That opening interval is the window's first interval. Pulse-free intervals before it do not count.
- R5: `los` falls on the edge that samples the M-th window interval, if the pulses counted in the window, times 8, are at least M.
- R6: If the window ends with too few pulses, `los` stays high and no interval counts until the next interval with `pulse_in` = 1, which opens a new window.
- R7: `los_irq` is high for exactly the cycle in which `los` has just risen, unless `int_mask` was 1 at that edge. It is never high otherwise.
- R8: An edge that samples `monitor_mode` = 1 forces `los` and `los_irq` to 0 and restarts all counting.
- R9: When `los` and `rx_ais_en` are 1 at an edge, `rx_data_out` is 1 after that edge. Otherwise `rx_data_out` takes `rx_data_in` sampled at that edge. `rx_clk_out` equals `mclk` while `los` and `rx_ais_en` are both 1, and `clk` otherwise.
- R10: When `los` and `tx_ais_en` are 1 at an edge, the transmit rails carry marks that alternate between them, with `tx_pos_out` first. Otherwise the rails take `tx_pos_in` and `tx_neg_in` sampled at that edge. `tx_clk_out` equals `mclk` while `los` and `tx_ais_en` are both 1, and `clk` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pulse-interval clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock used during alarm substitution |
| pulse_in | input | 1 | Pulse seen in this interval |
| rx_data_in | input | 1 | Recovered receive data |
| tx_pos_in | input | 1 | Transmit positive rail from the transmitter |
| tx_neg_in | input | 1 | Transmit negative rail from the transmitter |
| e1_mode | input | 1 | 1 selects E1 lengths, 0 selects T1 lengths |
| crit_sel | input | 1 | 0 selects the short lengths, 1 the long lengths |
| rx_ais_en | input | 1 | Enable receive-side all-ones substitution |
| tx_ais_en | input | 1 | Enable transmit-side all-ones substitution |
| monitor_mode | input | 1 | Line monitor mode; suppresses loss reporting |
| int_mask | input | 1 | Masks the loss interrupt |
| los | output | 1 | Loss-of-signal status |
| los_irq | output | 1 | One-cycle loss-declared interrupt |
| rx_data_out | output | 1 | Receive data or all ones |
| rx_clk_out | output | 1 | Recovered clock or master clock |
| tx_pos_out | output | 1 | Transmit positive rail or alarm marks |
| tx_neg_out | output | 1 | Transmit negative rail or alarm marks |
| tx_clk_out | output | 1 | Transmit clock: `clk` or master clock |

## Verification
The assertions check the following on every cycle:
- A rise of `los` always follows a pulse-free interval.
- The interrupt only coincides with a fresh rise, and follows every unmasked rise.
- Monitor mode holds the status low.
- The receive and transmit alarm outputs take their forced values one edge after loss is seen with the enables set.

The exact counts cannot be read from a single cycle. Only the bench's scenarios show them: the declare count per standard and criteria, the clear window opening on a pulse, the one-in-eight density limit at its boundary, and the restart after a failed window.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic [1:0] {
    CRIT_T1_SHORT = 2'b00,
    CRIT_E1_SHORT = 2'b01,
    CRIT_T1_LONG  = 2'b10,
    CRIT_E1_LONG  = 2'b11
  } crit_e;

  function automatic crit_e crit_decode(input logic long_sel, input logic is_e1);
    return crit_e'({long_sel, is_e1});
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/los_criteria_sel.sv
module los_criteria_sel #(
  parameter int unsigned CW          = 12,
  parameter int unsigned T1_N_SHORT  = 175,
  parameter int unsigned T1_M_SHORT  = 175,
  parameter int unsigned E1_N_SHORT  = 32,
  parameter int unsigned E1_M_SHORT  = 32,
  parameter int unsigned T1_N_LONG   = 1544,
  parameter int unsigned T1_M_LONG   = 1544,
  parameter int unsigned E1_N_LONG   = 2048,
  parameter int unsigned E1_M_LONG   = 2048
) (
  input  logic          e1_mode,
  input  logic          crit_sel,
  output logic [CW-1:0] n_lim,
  output logic [CW-1:0] m_lim
);
  import los_pkg::*;
  crit_e sel;

  always_comb begin
    sel = crit_decode(crit_sel, e1_mode);
    unique case (sel)
      CRIT_T1_SHORT: begin n_lim = CW'(T1_N_SHORT); m_lim = CW'(T1_M_SHORT); end
      CRIT_E1_SHORT: begin n_lim = CW'(E1_N_SHORT); m_lim = CW'(E1_M_SHORT); end
      CRIT_T1_LONG:  begin n_lim = CW'(T1_N_LONG);  m_lim = CW'(T1_M_LONG);  end
      default:       begin n_lim = CW'(E1_N_LONG);  m_lim = CW'(E1_M_LONG);  end
    endcase
  end
endmodule

// File: rtl/los_declare_ctr.sv
module los_declare_ctr #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          armed,
  input  logic          pulse,
  input  logic [CW-1:0] n_lim,
  output logic          declare
);
  logic [CW-1:0] zero_run;
  logic          at_limit;

  assign at_limit = (zero_run == n_lim - CW'(1));
  assign declare  = armed & ~clr & ~pulse & at_limit;

  always_ff @(posedge clk) begin
    if (rst || clr || !armed) begin
      zero_run <= '0;
    end else if (pulse || at_limit) begin
      zero_run <= '0;
    end else begin
      zero_run <= zero_run + CW'(1);
    end
  end
endmodule

// File: rtl/los_clear_window.sv
module los_clear_window #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          active,
  input  logic          pulse,
  input  logic [CW-1:0] m_lim,
  output logic          clear_hit
);
  localparam int unsigned DW = CW + 3;

  logic          open_q;
  logic [CW-1:0] span_q;
  logic [CW-1:0] marks_q;
  logic [CW-1:0] marks_nx;
  logic          last_iv;
  logic          dense;

  assign marks_nx  = marks_q + CW'(pulse);
  assign last_iv   = (span_q == m_lim - CW'(1));
  assign dense     = ({marks_nx, 3'b000} >= DW'(m_lim));
  assign clear_hit = active & ~clr & open_q & last_iv & dense;

  always_ff @(posedge clk) begin
    if (rst || clr || !active) begin
      open_q  <= 1'b0;
      span_q  <= '0;
      marks_q <= '0;
    end else if (!open_q) begin
      if (pulse) begin
        open_q  <= 1'b1;
        span_q  <= CW'(1);
        marks_q <= CW'(1);
      end
    end else if (last_iv) begin
      open_q  <= 1'b0;
      span_q  <= '0;
      marks_q <= '0;
    end else begin
      span_q  <= span_q + CW'(1);
      marks_q <= marks_nx;
    end
  end
endmodule

// File: rtl/los_ais_mux.sv
module los_ais_mux (
  input  logic clk,
  input  logic rst,
  input  logic mclk,
  input  logic los_q,
  input  logic rx_ais_en,
  input  logic tx_ais_en,
  input  logic rx_data_in,
  input  logic tx_pos_in,
  input  logic tx_neg_in,
  output logic rx_data_out,
  output logic rx_clk_out,
  output logic tx_pos_out,
  output logic tx_neg_out,
  output logic tx_clk_out
);
  logic rx_force;
  logic tx_force;
  logic phase_q;

  assign rx_force   = los_q & rx_ais_en;
  assign tx_force   = los_q & tx_ais_en;
  assign rx_clk_out = rx_force ? mclk : clk;
  assign tx_clk_out = tx_force ? mclk : clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_out <= 1'b0;
    end else begin
      rx_data_out <= rx_force ? 1'b1 : rx_data_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pos_out <= 1'b0;
      tx_neg_out <= 1'b0;
      phase_q    <= 1'b0;
    end else if (tx_force) begin
      tx_pos_out <= ~phase_q;
      tx_neg_out <= phase_q;
      phase_q    <= ~phase_q;
    end else begin
      tx_pos_out <= tx_pos_in;
      tx_neg_out <= tx_neg_in;
      phase_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/los_alarm_unit.sv
module los_alarm_unit #(
  parameter int unsigned T1_N_SHORT = 175,
  parameter int unsigned T1_M_SHORT = 175,
  parameter int unsigned E1_N_SHORT = 32,
  parameter int unsigned E1_M_SHORT = 32,
  parameter int unsigned T1_N_LONG  = 1544,
  parameter int unsigned T1_M_LONG  = 1544,
  parameter int unsigned E1_N_LONG  = 2048,
  parameter int unsigned E1_M_LONG  = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk,
  input  logic pulse_in,
  input  logic rx_data_in,
  input  logic tx_pos_in,
  input  logic tx_neg_in,
  input  logic e1_mode,
  input  logic crit_sel,
  input  logic rx_ais_en,
  input  logic tx_ais_en,
  input  logic monitor_mode,
  input  logic int_mask,
  output logic los,
  output logic los_irq,
  output logic rx_data_out,
  output logic rx_clk_out,
  output logic tx_pos_out,
  output logic tx_neg_out,
  output logic tx_clk_out
);
  localparam int unsigned MAX_LEN = los_pkg::max4(
    los_pkg::max4(T1_N_SHORT, E1_N_SHORT, T1_N_LONG, E1_N_LONG),
    los_pkg::max4(T1_M_SHORT, E1_M_SHORT, T1_M_LONG, E1_M_LONG), 1, 1);
  localparam int unsigned CW = $clog2(MAX_LEN + 1);

  logic [CW-1:0] n_lim;
  logic [CW-1:0] m_lim;
  logic          declare;
  logic          clear_hit;
  logic          los_q;
  logic          irq_q;

  los_criteria_sel #(
    .CW(CW),
    .T1_N_SHORT(T1_N_SHORT), .T1_M_SHORT(T1_M_SHORT),
    .E1_N_SHORT(E1_N_SHORT), .E1_M_SHORT(E1_M_SHORT),
    .T1_N_LONG(T1_N_LONG),   .T1_M_LONG(T1_M_LONG),
    .E1_N_LONG(E1_N_LONG),   .E1_M_LONG(E1_M_LONG)
  ) u_crit (
    .e1_mode (e1_mode),
    .crit_sel(crit_sel),
    .n_lim   (n_lim),
    .m_lim   (m_lim)
  );

  los_declare_ctr #(.CW(CW)) u_decl (
    .clk    (clk),
    .rst    (rst),
    .clr    (monitor_mode),
    .armed  (~los_q),
    .pulse  (pulse_in),
    .n_lim  (n_lim),
    .declare(declare)
  );

  los_clear_window #(.CW(CW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .clr      (monitor_mode),
    .active   (los_q),
    .pulse    (pulse_in),
    .m_lim    (m_lim),
    .clear_hit(clear_hit)
  );

  always_ff @(posedge clk) begin
    if (rst || monitor_mode) begin
      los_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= declare & ~int_mask;
      if (declare) begin
        los_q <= 1'b1;
      end else if (clear_hit) begin
        los_q <= 1'b0;
      end
    end
  end

  assign los     = los_q;
  assign los_irq = irq_q;

  los_ais_mux u_ais (
    .clk        (clk),
    .rst        (rst),
    .mclk       (mclk),
    .los_q      (los_q),
    .rx_ais_en  (rx_ais_en),
    .tx_ais_en  (tx_ais_en),
    .rx_data_in (rx_data_in),
    .tx_pos_in  (tx_pos_in),
    .tx_neg_in  (tx_neg_in),
    .rx_data_out(rx_data_out),
    .rx_clk_out (rx_clk_out),
    .tx_pos_out (tx_pos_out),
    .tx_neg_out (tx_neg_out),
    .tx_clk_out (tx_clk_out)
  );
endmodule

// File: rtl/los_alarm_unit_chk.sv
module los_alarm_unit_chk (
  input logic clk,
  input logic rst,
  input logic pulse_in,
  input logic monitor_mode,
  input logic int_mask,
  input logic rx_ais_en,
  input logic tx_ais_en,
  input logic los,
  input logic los_irq,
  input logic rx_data_out,
  input logic tx_pos_out,
  input logic tx_neg_out
);
  // R2
  rise_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> $past(!pulse_in));

  // R7
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    los_irq |-> (los && !$past(los)));

  // R7
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(los) && !$past(int_mask)) |-> los_irq);

  // R8
  monitor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    monitor_mode |=> (!los && !los_irq));

  // R9
  rx_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (los && rx_ais_en) |=> rx_data_out);

  // R10
  tx_alarm_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (los && tx_ais_en) |=> (tx_pos_out != tx_neg_out));
endmodule

bind los_alarm_unit los_alarm_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pulse_in    (pulse_in),
  .monitor_mode(monitor_mode),
  .int_mask    (int_mask),
  .rx_ais_en   (rx_ais_en),
  .tx_ais_en   (tx_ais_en),
  .los         (los),
  .los_irq     (los_irq),
  .rx_data_out (rx_data_out),
  .tx_pos_out  (tx_pos_out),
  .tx_neg_out  (tx_neg_out)
);

// File: tb/los_alarm_unit_tb.sv
module los_alarm_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mclk = 1'b1;
  logic pulse_in = 1'b0, rx_data_in = 1'b0, tx_pos_in = 1'b0, tx_neg_in = 1'b0;
  logic e1_mode = 1'b1, crit_sel = 1'b0, rx_ais_en = 1'b0, tx_ais_en = 1'b0;
  logic monitor_mode = 1'b0, int_mask = 1'b0;
  logic los, los_irq, rx_data_out, rx_clk_out, tx_pos_out, tx_neg_out, tx_clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit m_los, m_irq, m_act, m_rx, m_txp, m_txn, m_ph;
  int m_zero, m_span, m_marks;

  always #10 clk = ~clk;

  los_alarm_unit u_dut (
    .clk(clk), .rst(rst), .mclk(mclk), .pulse_in(pulse_in), .rx_data_in(rx_data_in),
    .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in), .e1_mode(e1_mode), .crit_sel(crit_sel),
    .rx_ais_en(rx_ais_en), .tx_ais_en(tx_ais_en), .monitor_mode(monitor_mode),
    .int_mask(int_mask), .los(los), .los_irq(los_irq), .rx_data_out(rx_data_out),
    .rx_clk_out(rx_clk_out), .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out),
    .tx_clk_out(tx_clk_out)
  );

  // R3 lengths
  function automatic int len_n(bit e1, bit lg);
    if (lg) return e1 ? 2048 : 1544;
    return e1 ? 32 : 175;
  endfunction
  function automatic int len_m(bit e1, bit lg);
    return len_n(e1, lg);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int n, m;
    n = len_n(e1_mode, crit_sel);
    m = len_m(e1_mode, crit_sel);
    if (rst) begin
      m_los = 0; m_irq = 0; m_act = 0; m_zero = 0; m_span = 0; m_marks = 0;
      m_rx = 0; m_txp = 0; m_txn = 0; m_ph = 0;
      return;
    end
    m_rx = (m_los && rx_ais_en) ? 1'b1 : rx_data_in;
    if (m_los && tx_ais_en) begin
      m_txp = ~m_ph; m_txn = m_ph; m_ph = ~m_ph;
    end else begin
      m_txp = tx_pos_in; m_txn = tx_neg_in; m_ph = 0;
    end
    m_irq = 0;
    if (monitor_mode) begin
      m_los = 0; m_act = 0; m_zero = 0; m_span = 0; m_marks = 0;
    end else if (!m_los) begin
      if (pulse_in) m_zero = 0;
      else if (m_zero == n - 1) begin
        m_los = 1; m_zero = 0; m_irq = !int_mask; m_act = 0;
      end else m_zero++;
    end else if (!m_act) begin
      if (pulse_in) begin m_act = 1; m_span = 1; m_marks = 1; end
    end else begin
      if (m_span == m - 1) begin
        if ((m_marks + int'(pulse_in)) * 8 >= m) m_los = 0;
        m_act = 0;
      end else begin
        m_span++; m_marks += int'(pulse_in);
      end
    end
  endtask

  task automatic compare_all();
    check("R2/R5 los", los, m_los);
    check("R7 los_irq", los_irq, m_irq);
    check("R9 rx_data_out", rx_data_out, m_rx);
    check("R9 rx_clk_out", rx_clk_out, (m_los && rx_ais_en) ? mclk : clk);
    check("R10 tx_pos_out", tx_pos_out, m_txp);
    check("R10 tx_neg_out", tx_neg_out, m_txn);
    check("R10 tx_clk_out", tx_clk_out, (m_los && tx_ais_en) ? mclk : clk);
  endtask

  // drive one interval, let one edge pass, compare at the falling edge
  task automatic step(logic p);
    pulse_in   = p;
    rx_data_in = 1'($urandom_range(0, 1));
    tx_pos_in  = 1'($urandom_range(0, 1));
    tx_neg_in  = tx_pos_in ? 1'b0 : 1'($urandom_range(0, 1));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic zeros(int k);
    for (int i = 0; i < k; i++) step(1'b0);
  endtask

  // window of len intervals: pulse first, np pulses in total
  task automatic window(int len, int np);
    for (int i = 0; i < len; i++) step(i < np);
  endtask

  task automatic random_run(int cycles, int pct);
    for (int i = 0; i < cycles; i++) step($urandom_range(0, 99) < pct);
  endtask

  task automatic quiesce();
    monitor_mode = 1'b1;
    step(1'b0);
    monitor_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    @(posedge clk); model_edge();
    @(posedge clk); model_edge();
    @(negedge clk);
    // R1 reset state
    check("R1 los", los, 1'b0);
    check("R1 los_irq", los_irq, 1'b0);
    check("R1 rx_data_out", rx_data_out, 1'b0);
    check("R1 tx_pos_out", tx_pos_out, 1'b0);
    check("R1 tx_neg_out", tx_neg_out, 1'b0);
    rst = 1'b0;

    // E1 short lengths, directed declare boundary (R2, R3)
    e1_mode = 1'b1; crit_sel = 1'b0;
    quiesce();
    step(1'b1); zeros(31);
    check("R2 no declare at N-1", los, 1'b0);
    step(1'b1); zeros(31);
    check("R2 pulse restarts count", los, 1'b0);
    step(1'b0);
    check("R2 declare at N=32", los, 1'b1);
    check("R7 irq with declare", los_irq, 1'b1);
    step(1'b0);
    check("R7 irq one cycle", los_irq, 1'b0);

    // R4 idle before pulse, R6 failing window then restart, R5 clear
    rx_ais_en = 1'b1; tx_ais_en = 1'b1;
    zeros(40);
    check("R4 no window without pulse", los, 1'b1);
    check("R9 rx all ones", rx_data_out, 1'b1);
    window(32, 3);
    check("R6 three of 32 fails", los, 1'b1);
    step(1'b0);
    window(31, 4);
    check("R5 not before M-th", los, 1'b1);
    step(1'b0);
    check("R5 four of 32 clears", los, 1'b0);

    // T1 short: 21 pulses fail, 22 pass (R3, R5, R6)
    e1_mode = 1'b0;
    quiesce();
    zeros(174);
    check("R3 T1 no declare at 174", los, 1'b0);
    int_mask = 1'b1;
    step(1'b0);
    check("R3 T1 declare at 175", los, 1'b1);
    check("R7 masked irq", los_irq, 1'b0);
    int_mask = 1'b0;
    window(175, 21);
    check("R6 T1 21 pulses fail", los, 1'b1);
    window(175, 22);
    check("R5 T1 22 pulses clear", los, 1'b0);

    // R8 monitor mode while loss active
    e1_mode = 1'b1;
    zeros(32);
    check("R8 precondition los", los, 1'b1);
    monitor_mode = 1'b1;
    step(1'b0);
    check("R8 monitor clears los", los, 1'b0);
    zeros(40);
    check("R8 monitor holds los low", los, 1'b0);
    monitor_mode = 1'b0;

    // long criteria (R3)
    crit_sel = 1'b1;
    quiesce();
    zeros(2047);
    check("R3 E1 long no declare at 2047", los, 1'b0);
    step(1'b0);
    check("R3 E1 long declare at 2048", los, 1'b1);
    window(2048, 256);
    check("R5 E1 long clear at 1/8", los, 0);
    e1_mode = 1'b0;
    zeros(1544);
    check("R3 T1 long declare at 1544", los, 1'b1);
    window(1544, 192);
    check("R6 T1 long 192 fails", los, 1'b1);
    window(1544, 193);
    check("R5 T1 long 193 clears", los, 1'b0);

    // random mix over all settings, model compared every interval
    for (int cfg = 0; cfg < 8; cfg++) begin
      e1_mode   = cfg[0];
      crit_sel  = 1'b0;
      rx_ais_en = cfg[1];
      tx_ais_en = cfg[2];
      int_mask  = 1'($urandom_range(0, 1));
      random_run(300, 60);
      zeros(180);
      random_run(600, 15);
      random_run(400, 5);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule